// File: doc/BRIEF.md
# Kernel Dependency Scoreboard Dispatcher

This block sits between a host and a small array of processors and decides when each queued kernel may start. The host pushes launch requests into an eight-entry in-order queue. Each request names a kernel by a 3-bit ID, gives a dependency mask (bit i set means the kernel needs kernel i to have completed) and a processor mask (bit p set means the kernel wants processor p). A completion scoreboard holds one bit per kernel ID, and every processor has a small slot state machine that tracks whether it is occupied and which kernel it holds.

Each cycle the block looks at the registered scoreboard and the registered processor occupancy, picks the oldest queued entry whose dependencies are all complete and whose processors are all free, removes it from the queue and launches it. A younger eligible entry may overtake an older blocked one. Launching raises a one-cycle start strobe on every processor in the mask and presents the kernel ID beside it. A done pulse from an occupied processor frees it and marks its kernel complete. The host can begin a new epoch, which wipes the completion bits. A request whose processor mask is empty is refused and flagged.

Each processor slot state machine has three states. SLOT_IDLE is free; the transition launch moves it to SLOT_LAUNCH, where the start strobe is high for one cycle. From SLOT_LAUNCH the transition settle moves it to SLOT_RUN, or the transition retire moves it straight back to SLOT_IDLE when a done pulse arrives in that cycle. From SLOT_RUN the transition retire, taken on a done pulse, returns it to SLOT_IDLE.

Top module: `kernel_dispatch`

## Requirements
- R1: After reset the queue is empty, req_ready is 1, proc_start is 0, start_kid is 0, req_reject is 0 and all kern_done bits are 0.
- R2: A request is taken into the queue in a cycle where req_valid and req_ready are both 1; req_ready is 0 exactly while 8 requests are held, and a request offered while req_ready is 0 is lost.
- R3: A taken request whose req_procs is 0 is not queued and makes req_reject 1 in the following cycle only.
- R4: A kernel is launched only in a cycle where every bit set in its dependency mask is also set in the completion vector (bit i of the vector stands for kernel ID i).
- R5: A kernel is launched only when every processor in its mask is free; a processor never holds two kernels.
- R6: At most one kernel is launched per cycle; among eligible entries the one taken earliest into the queue goes first, and a blocked older entry does not hold back a younger eligible one.
- R7: A kernel that is eligible in cycle t makes proc_start equal to its processor mask in cycle t+1 for that cycle only, with start_kid equal to its ID; start_kid holds its value until the next launch.
- R8: A proc_done bit for an occupied processor frees it and sets the kern_done bit of the kernel it holds from the next cycle; a proc_done bit for a free processor has no effect.
- R9: epoch_clr clears all kern_done bits from the next cycle, except that a completion arriving in the same cycle is kept.
- R10: Eligibility uses the state held at the start of the cycle, so a processor freed or a kernel completed by a done pulse in cycle t can first be used for a launch decided in cycle t+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host offers a launch request |
| req_ready | output | 1 | Queue has room for a request |
| req_kid | input | 3 | Kernel ID of the request |
| req_deps | input | 8 | Kernels that must be complete first |
| req_procs | input | 4 | Processors the kernel needs |
| req_reject | output | 1 | Previous-cycle request refused for an empty processor mask |
| epoch_clr | input | 1 | Start a new epoch: clear completion bits |
| proc_done | input | 4 | Per-processor done pulses |
| proc_start | output | 4 | Per-processor start strobes |
| start_kid | output | 3 | ID of the kernel last launched |
| kern_done | output | 8 | Completion vector, one bit per kernel ID |

## Verification
The sharpest overlap is a done pulse arriving in the same cycle that a queued kernel waits for the very processor or kernel that pulse releases: the bench provokes it by holding a second kernel behind a running one and pulsing done while the waiter is queued, and the reference model, which decides eligibility from the state at the start of the cycle, expects the launch one cycle later. A second overlap, an epoch clear together with a done pulse, is driven on purpose and judged by the completion vector in the following cycle. A long stretch of random requests, done pulses and epoch clears then lets the model compare strobes, IDs, ready, reject and completion bits on every clock.

// File: rtl/kdisp_pkg.sv
package kdisp_pkg;

    localparam int DEF_KERNELS = 8;
    localparam int DEF_PROCS   = 4;
    localparam int DEF_DEPTH   = 8;

    typedef enum logic [1:0] {
        SLOT_IDLE   = 2'd0,
        SLOT_LAUNCH = 2'd1,
        SLOT_RUN    = 2'd2
    } slot_state_e;

endpackage

// File: rtl/kdisp_queue.sv
module kdisp_queue #(
    parameter int DEPTH = 8,
    parameter int NK    = 8,
    parameter int NP    = 4,
    localparam int KW   = (NK > 1) ? $clog2(NK) : 1,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enq_i,
    input  logic [KW-1:0] enq_kid_i,
    input  logic [NK-1:0] enq_deps_i,
    input  logic [NP-1:0] enq_procs_i,
    input  logic [NK-1:0] done_vec_i,
    input  logic [NP-1:0] busy_i,
    output logic          full_o,
    output logic          grant_o,
    output logic [KW-1:0] grant_kid_o,
    output logic [NK-1:0] grant_deps_o,
    output logic [NP-1:0] grant_procs_o
);

    logic [KW-1:0] kid_q   [DEPTH];
    logic [NK-1:0] deps_q  [DEPTH];
    logic [NP-1:0] procs_q [DEPTH];
    logic [KW-1:0] kid_n   [DEPTH];
    logic [NK-1:0] deps_n  [DEPTH];
    logic [NP-1:0] procs_n [DEPTH];
    logic [CW-1:0] count_q, count_n, cnt_after;
    logic [IW-1:0] sel, wr_idx;
    logic          grant;

    // oldest-first pick: entry 0 is always the oldest
    always_comb begin
        grant = 1'b0;
        sel   = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (!grant && (CW'(i) < count_q) &&
                ((deps_q[i] & ~done_vec_i) == '0) &&
                ((procs_q[i] & busy_i) == '0)) begin
                grant = 1'b1;
                sel   = IW'(i);
            end
        end
    end

    // compaction on removal, append behind the survivors
    always_comb begin
        cnt_after = count_q - (grant ? CW'(1) : CW'(0));
        wr_idx    = cnt_after[IW-1:0];
        for (int i = 0; i < DEPTH; i++) begin
            kid_n[i]   = kid_q[i];
            deps_n[i]  = deps_q[i];
            procs_n[i] = procs_q[i];
        end
        for (int i = 0; i < DEPTH - 1; i++) begin
            if (grant && (i >= int'(sel))) begin
                kid_n[i]   = kid_q[i+1];
                deps_n[i]  = deps_q[i+1];
                procs_n[i] = procs_q[i+1];
            end
        end
        if (enq_i) begin
            kid_n[wr_idx]   = enq_kid_i;
            deps_n[wr_idx]  = enq_deps_i;
            procs_n[wr_idx] = enq_procs_i;
        end
        count_n = cnt_after + (enq_i ? CW'(1) : CW'(0));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else begin
            count_q <= count_n;
        end
        for (int i = 0; i < DEPTH; i++) begin
            kid_q[i]   <= kid_n[i];
            deps_q[i]  <= deps_n[i];
            procs_q[i] <= procs_n[i];
        end
    end

    assign full_o        = (count_q == CW'(DEPTH));
    assign grant_o       = grant;
    assign grant_kid_o   = kid_q[sel];
    assign grant_deps_o  = deps_q[sel];
    assign grant_procs_o = procs_q[sel];

    // R2: nothing is written into a full queue
    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        enq_i |-> !full_o);

    // R3: an empty processor mask never reaches the queue
    assert_nonempty_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        enq_i |-> (enq_procs_i != '0));

    // R2: occupancy moves by at most one per cycle and never exceeds depth
    assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CW'(DEPTH));

endmodule

// File: rtl/kdisp_slot.sv
module kdisp_slot
    import kdisp_pkg::*;
#(
    parameter int NK  = 8,
    localparam int KW = (NK > 1) ? $clog2(NK) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          launch_i,
    input  logic [KW-1:0] launch_kid_i,
    input  logic          done_i,
    output logic          busy_o,
    output logic          start_o,
    output logic          retire_o,
    output logic [KW-1:0] owner_o
);

    slot_state_e state_q, state_n;
    logic [KW-1:0] owner_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SLOT_IDLE;
        end else begin
            state_q <= state_n;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owner_q <= '0;
        end else if (launch_i) begin
            owner_q <= launch_kid_i;
        end
    end

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            SLOT_IDLE:   if (launch_i) state_n = SLOT_LAUNCH;
            SLOT_LAUNCH: state_n = done_i ? SLOT_IDLE : SLOT_RUN;
            SLOT_RUN:    if (done_i) state_n = SLOT_IDLE;
            default:     state_n = SLOT_IDLE;
        endcase
    end

    always_comb begin
        busy_o  = 1'b0;
        start_o = 1'b0;
        unique case (state_q)
            SLOT_IDLE:   ;
            SLOT_LAUNCH: begin busy_o = 1'b1; start_o = 1'b1; end
            SLOT_RUN:    busy_o = 1'b1;
            default:     ;
        endcase
    end

    assign retire_o = done_i && busy_o;
    assign owner_o  = owner_q;

    // R5: a launch only ever lands on a free processor
    assert_launch_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        launch_i |-> (state_q == SLOT_IDLE));

    // R7: the start strobe lasts a single cycle
    assert_strobe_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> !start_o);

endmodule

// File: rtl/kdisp_scoreboard.sv
module kdisp_scoreboard #(
    parameter int NK  = 8,
    parameter int NP  = 4,
    localparam int KW = (NK > 1) ? $clog2(NK) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  epoch_clr_i,
    input  logic [NP-1:0]         retire_i,
    input  logic [NP-1:0][KW-1:0] owner_i,
    output logic [NK-1:0]         done_vec_o
);

    logic [NK-1:0] done_q, set_mask;

    always_comb begin
        set_mask = '0;
        for (int p = 0; p < NP; p++) begin
            if (retire_i[p]) set_mask[owner_i[p]] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= '0;
        end else begin
            done_q <= (epoch_clr_i ? '0 : done_q) | set_mask;
        end
    end

    assign done_vec_o = done_q;

    // R9: an epoch clear with no completion leaves nothing set
    assert_epoch_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (epoch_clr_i && (retire_i == '0)) |=> (done_vec_o == '0));

    // R8: without a clear, completion bits are never lost
    assert_done_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !epoch_clr_i |=> ((done_vec_o & $past(done_vec_o)) == $past(done_vec_o)));

endmodule

// File: rtl/kernel_dispatch.sv
module kernel_dispatch
    import kdisp_pkg::*;
#(
    parameter int NUM_KERNELS = DEF_KERNELS,
    parameter int NUM_PROCS   = DEF_PROCS,
    parameter int QUEUE_DEPTH = DEF_DEPTH,
    localparam int KW = (NUM_KERNELS > 1) ? $clog2(NUM_KERNELS) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic [KW-1:0]          req_kid,
    input  logic [NUM_KERNELS-1:0] req_deps,
    input  logic [NUM_PROCS-1:0]   req_procs,
    output logic                   req_reject,
    input  logic                   epoch_clr,
    input  logic [NUM_PROCS-1:0]   proc_done,
    output logic [NUM_PROCS-1:0]   proc_start,
    output logic [KW-1:0]          start_kid,
    output logic [NUM_KERNELS-1:0] kern_done
);

    logic                   q_full, accept, enq;
    logic                   grant;
    logic [KW-1:0]          grant_kid;
    logic [NUM_KERNELS-1:0] grant_deps;
    logic [NUM_PROCS-1:0]   grant_procs;
    logic [NUM_PROCS-1:0]   busy, retire;
    logic [KW-1:0]          owner_arr [NUM_PROCS];
    logic [NUM_PROCS-1:0][KW-1:0] owner_pk;
    logic                   reject_q;
    logic [KW-1:0]          start_kid_q;

    assign req_ready = !q_full;
    assign accept    = req_valid && req_ready;
    assign enq       = accept && (req_procs != '0);

    kdisp_queue #(
        .DEPTH (QUEUE_DEPTH),
        .NK    (NUM_KERNELS),
        .NP    (NUM_PROCS)
    ) u_queue (
        .clk           (clk),
        .rst_n         (rst_n),
        .enq_i         (enq),
        .enq_kid_i     (req_kid),
        .enq_deps_i    (req_deps),
        .enq_procs_i   (req_procs),
        .done_vec_i    (kern_done),
        .busy_i        (busy),
        .full_o        (q_full),
        .grant_o       (grant),
        .grant_kid_o   (grant_kid),
        .grant_deps_o  (grant_deps),
        .grant_procs_o (grant_procs)
    );

    for (genvar p = 0; p < NUM_PROCS; p++) begin : g_slot
        kdisp_slot #(.NK(NUM_KERNELS)) u_slot (
            .clk          (clk),
            .rst_n        (rst_n),
            .launch_i     (grant && grant_procs[p]),
            .launch_kid_i (grant_kid),
            .done_i       (proc_done[p]),
            .busy_o       (busy[p]),
            .start_o      (proc_start[p]),
            .retire_o     (retire[p]),
            .owner_o      (owner_arr[p])
        );
    end

    always_comb begin
        for (int p = 0; p < NUM_PROCS; p++) owner_pk[p] = owner_arr[p];
    end

    kdisp_scoreboard #(
        .NK (NUM_KERNELS),
        .NP (NUM_PROCS)
    ) u_score (
        .clk         (clk),
        .rst_n       (rst_n),
        .epoch_clr_i (epoch_clr),
        .retire_i    (retire),
        .owner_i     (owner_pk),
        .done_vec_o  (kern_done)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reject_q    <= 1'b0;
            start_kid_q <= '0;
        end else begin
            reject_q <= accept && (req_procs == '0);
            if (grant) start_kid_q <= grant_kid;
        end
    end

    assign req_reject = reject_q;
    assign start_kid  = start_kid_q;

    // R4: the launched kernel's producers are all complete
    assert_deps_met_R4: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> ((grant_deps & ~kern_done) == '0));

    // R5: the launched kernel's processors are all free
    assert_free_procs_R5: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> ((grant_procs & busy) == '0));

    // R3: a reject flag always traces back to an empty-mask request
    assert_reject_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        req_reject |-> $past(req_valid && req_ready && (req_procs == '0)));

    // R7: strobes appear one cycle after a launch decision, with its mask
    assert_start_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
        grant |=> (proc_start == $past(grant_procs)) && (start_kid == $past(grant_kid)));

endmodule

// File: tb/kernel_dispatch_tb_top.sv
`timescale 1ns/1ps
module kernel_dispatch_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic [2:0] req_kid = '0;
    logic [7:0] req_deps = '0;
    logic [3:0] req_procs = '0;
    logic       req_reject;
    logic       epoch_clr = 1'b0;
    logic [3:0] proc_done = '0;
    logic [3:0] proc_start;
    logic [2:0] start_kid;
    logic [7:0] kern_done;

    always #2.5 clk = ~clk;

    kernel_dispatch dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_kid    (req_kid),
        .req_deps   (req_deps),
        .req_procs  (req_procs),
        .req_reject (req_reject),
        .epoch_clr  (epoch_clr),
        .proc_done  (proc_done),
        .proc_start (proc_start),
        .start_kid  (start_kid),
        .kern_done  (kern_done)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    string phase = "R1";

    // behavioural reference model
    typedef struct { int kid; int deps; int procs; } ent_t;
    ent_t       mq[$];
    logic [3:0] m_busy  = '0;
    int         m_owner [4];
    logic [7:0] m_done  = '0;
    logic [3:0] m_start = '0;
    logic [2:0] m_skid  = '0;
    logic       m_rej   = 1'b0;

    task automatic check(string tag, int got, int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s (%s): got %0h expected %0h", tag, phase, got, exp);
        end
    endtask

    task automatic compare();
        check("R2 req_ready", int'(req_ready), (mq.size() < 8) ? 1 : 0);
        check("R3 req_reject", int'(req_reject), int'(m_rej));
        check("R7 proc_start", int'(proc_start), int'(m_start));
        check("R7 start_kid", int'(start_kid), int'(m_skid));
        check("R8 kern_done", int'(kern_done), int'(m_done));
    endtask

    task automatic model_step();
        int sel = -1;
        logic [7:0] nd;
        logic [3:0] nb;
        bit acc;
        for (int i = 0; i < mq.size(); i++) begin
            if (sel < 0 && ((mq[i].deps & ~int'(m_done)) == 0) &&
                ((mq[i].procs & int'(m_busy)) == 0)) sel = i;
        end
        acc = req_valid && (mq.size() < 8);
        nd = epoch_clr ? 8'h00 : m_done;
        nb = m_busy;
        for (int p = 0; p < 4; p++) begin
            if (proc_done[p] && m_busy[p]) begin
                nb[p] = 1'b0;
                nd[m_owner[p]] = 1'b1;
            end
        end
        m_start = '0;
        if (sel >= 0) begin
            m_start = mq[sel].procs[3:0];
            for (int p = 0; p < 4; p++) begin
                if (mq[sel].procs[p]) begin
                    nb[p] = 1'b1;
                    m_owner[p] = mq[sel].kid;
                end
            end
            m_skid = mq[sel].kid[2:0];
            mq.delete(sel);
        end
        m_rej = acc && (req_procs == 4'd0);
        if (acc && req_procs != 4'd0)
            mq.push_back('{kid: int'(req_kid), deps: int'(req_deps), procs: int'(req_procs)});
        m_done = nd;
        m_busy = nb;
    endtask

    // one clock: model, edge, then sample and clear one-shot inputs
    task automatic cycle();
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare();
        req_valid = 1'b0;
        proc_done = '0;
        epoch_clr = 1'b0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cycle();
    endtask

    task automatic push(int kid, int deps, int procs);
        req_valid = 1'b1;
        req_kid   = kid[2:0];
        req_deps  = deps[7:0];
        req_procs = procs[3:0];
        cycle();
    endtask

    task automatic done(int mask);
        proc_done = mask[3:0];
        cycle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int p = 0; p < 4; p++) m_owner[p] = 0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        phase = "R1";
        compare();
        check("R1 proc_start zero", int'(proc_start), 0);
        idle(1);

        // older entry blocked by a dependency; younger one overtakes
        phase = "R6";
        push(1, 8'h01, 4'b0001);
        push(0, 8'h00, 4'b0010);
        idle(1);
        check("R6 younger eligible launched", int'(start_kid), 0);
        phase = "R4";
        done(4'b0010);
        idle(3);
        check("R4 dependent launched after producer", int'(start_kid), 1);
        done(4'b0001);
        idle(1);

        // processor overlap forces the second kernel to wait
        phase = "R5";
        push(2, 8'h00, 4'b0011);
        push(3, 8'h00, 4'b0010);
        idle(3);
        done(4'b0001);
        idle(2);
        done(4'b0010);
        idle(3);
        done(4'b0010);
        idle(1);

        phase = "R3";
        push(4, 8'h00, 4'b0000);
        idle(2);

        phase = "R8";
        done(4'b0100);
        idle(2);

        // fill the queue behind a busy processor
        phase = "R2";
        push(5, 8'h00, 4'b1000);
        idle(2);
        for (int i = 0; i < 9; i++) push(6, 8'h00, 4'b1000);
        check("R2 ready low when full", int'(req_ready), 0);
        idle(1);
        for (int i = 0; i < 10; i++) begin
            done(4'b1000);
            idle(1);
        end

        phase = "R9";
        epoch_clr = 1'b1;
        cycle();
        check("R9 cleared", int'(kern_done), 0);
        push(7, 8'h00, 4'b0001);
        idle(2);
        epoch_clr = 1'b1;
        proc_done = 4'b0001;
        cycle();
        check("R9 same-cycle completion kept", int'(kern_done), 8'h80);
        idle(1);

        // done and a waiting kernel on the same processor
        phase = "R10";
        push(1, 8'h00, 4'b0100);
        push(2, 8'h00, 4'b0100);
        idle(2);
        done(4'b0100);
        check("R10 no launch in freeing cycle edge", int'(proc_start), 0);
        idle(1);
        check("R10 launch one cycle later", int'(start_kid), 2);
        done(4'b0100);
        idle(2);

        // random mix
        phase = "RND";
        for (int n = 0; n < 4000; n++) begin
            if (($urandom % 3) == 0) begin
                req_valid = 1'b1;
                req_kid   = 3'($urandom);
                req_deps  = 8'($urandom & $urandom & $urandom);
                req_procs = (($urandom % 10) == 0) ? 4'd0 : 4'($urandom);
            end
            proc_done = 4'($urandom & $urandom);
            epoch_clr = (($urandom % 40) == 0);
            cycle();
        end

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule